// File: doc/BRIEF.md
# Ratio and Voltage Transition Sequencer

This block moves a multi-core processor between its nominal operating point and a reduced one when all cores go idle in the enhanced halt state. It drives the core clock ratio code and the supply voltage-ID code. It asks the clock and voltage subsystems to apply each change through a request strobe. Each subsystem answers with a done signal. The front-side bus frequency is never touched: only the internal core ratio changes, and the block has no bus clock output at all.

Going down, the ratio is lowered first and the voltage second, so the core never runs fast on a reduced supply. Coming back up, the order is reversed: the voltage is raised first, then the ratio. The core keeps running at the low ratio until the exit sequence completes. Entry needs every core halted and the feature-enable bit set. A break event starts the exit.

The states are `ST_NOM`, `ST_ENT_RATIO`, `ST_ENT_VID`, `ST_LOW`, `ST_EXIT_VID` and `ST_EXIT_RATIO`. The transitions are:

- `ST_NOM` goes to `ST_ENT_RATIO` when all cores are halted, enable is set and no break is present.
- `ST_ENT_RATIO` goes to `ST_ENT_VID` on ratio done. If a break was seen during this step, it goes to `ST_EXIT_RATIO` instead.
- `ST_ENT_VID` goes to `ST_LOW` on voltage done. If a break was seen during this step, it goes to `ST_EXIT_VID` instead.
- `ST_LOW` goes to `ST_EXIT_VID` on a break event or on enable cleared.
- `ST_EXIT_VID` goes to `ST_EXIT_RATIO` on voltage done.
- `ST_EXIT_RATIO` goes to `ST_NOM` on ratio done.

Top module: `ratio_vid_sequencer`

## Requirements
- R1: After reset, ratio_o equals ratio_nom_i, vid_o equals vid_nom_i, both request strobes are low and low_pwr_o is low.
- R2: Entry begins only when every bit of halted_i is 1, enable_i is 1 and brk_i is 0. With only some cores halted, the outputs stay at the nominal codes with no request.
- R3: On entry, ratio_o switches to ratio_low_i and ratio_req_o rises while vid_o is still vid_nom_i. vid_o becomes vid_low_i, with vid_req_o, only after the ratio done has been sampled.
- R4: On exit, vid_o returns to vid_nom_i under vid_req_o while ratio_o stays at ratio_low_i. ratio_o returns to ratio_nom_i only after the voltage done has been sampled.
- R5: A request strobe stays high until its done input is sampled high at a clock edge. The state advances on that edge, and outputs show the next step one cycle later.
- R6: A break event during an entry step lets that step finish. If it came during the ratio step, only the ratio is restored. If it came during the voltage step, the exit starts with the voltage. low_pwr_o is never raised in either case.
- R7: low_pwr_o is high only in the settled low state. That state is left only on brk_i or a cleared enable_i. Other activity such as snoops, or changes on halted_i, has no effect.
- R8: With enable_i at 0, the block leaves the nominal codes unchanged whatever halted_i shows.
- R9: ratio_req_o and vid_req_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| halted_i | input | NUM_CORES | Per-core halted status |
| enable_i | input | 1 | Feature enable for the enhanced halt state |
| brk_i | input | 1 | Break event |
| ratio_nom_i | input | RATIO_W | Nominal core ratio code |
| ratio_low_i | input | RATIO_W | Low core ratio code |
| vid_nom_i | input | VID_W | Nominal voltage-ID code |
| vid_low_i | input | VID_W | Low voltage-ID code |
| ratio_done_i | input | 1 | Clock subsystem has applied the ratio |
| vid_done_i | input | 1 | Voltage subsystem has applied the voltage |
| ratio_o | output | RATIO_W | Commanded core ratio code |
| vid_o | output | VID_W | Commanded voltage-ID code |
| ratio_req_o | output | 1 | Ratio change request strobe |
| vid_req_o | output | 1 | Voltage change request strobe |
| low_pwr_o | output | 1 | Settled in the low operating point |

## Verification
The bench builds the block with NUM_CORES=3, RATIO_W=5 and VID_W=6. Three cores make it possible to test partial halt patterns with one or two cores still running. The nominal and low codes all differ, so each step of both orderings can be told apart at the ports. The bench's done responders run with latencies from zero to three cycles. This lets a break event land inside the ratio step or inside the voltage step, reaching both abort paths.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
    typedef enum logic [2:0] {
        ST_NOM        = 3'd0,
        ST_ENT_RATIO  = 3'd1,
        ST_ENT_VID    = 3'd2,
        ST_LOW        = 3'd3,
        ST_EXIT_VID   = 3'd4,
        ST_EXIT_RATIO = 3'd5
    } rvs_state_e;

    typedef struct packed {
        logic ratio_low_sel;
        logic vid_low_sel;
        logic ratio_req;
        logic vid_req;
        logic low_pwr;
    } rvs_ctl_t;
endpackage

// File: rtl/rvs_entry_qual.sv
module rvs_entry_qual #(
    parameter int NUM_CORES = 2
) (
    input  logic [NUM_CORES-1:0] halted_i,
    input  logic                 enable_i,
    output logic                 enter_ok_o
);
    logic [NUM_CORES-1:0] chain;

    generate
        for (genvar g = 0; g < NUM_CORES; g++) begin : g_and
            if (g == 0) begin : g_first
                assign chain[g] = halted_i[g];
            end else begin : g_rest
                assign chain[g] = chain[g-1] & halted_i[g];
            end
        end
    endgenerate

    assign enter_ok_o = enable_i & chain[NUM_CORES-1];
endmodule

// File: rtl/rvs_fsm.sv
module rvs_fsm
    import rvs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enter_ok_i,
    input  logic       enable_i,
    input  logic       brk_i,
    input  logic       ratio_done_i,
    input  logic       vid_done_i,
    output rvs_state_e state_o
);
    rvs_state_e state_q, state_d;
    logic       brk_pend_q, brk_pend_d;
    logic       abort;

    assign abort = brk_pend_q | brk_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_NOM;
            brk_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            brk_pend_q <= brk_pend_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        brk_pend_d = 1'b0;
        unique case (state_q)
            ST_NOM: begin
                if (enter_ok_i && !brk_i) state_d = ST_ENT_RATIO;
            end
            ST_ENT_RATIO: begin
                brk_pend_d = abort;
                if (ratio_done_i) state_d = abort ? ST_EXIT_RATIO : ST_ENT_VID;
            end
            ST_ENT_VID: begin
                brk_pend_d = abort;
                if (vid_done_i) state_d = abort ? ST_EXIT_VID : ST_LOW;
            end
            ST_LOW: begin
                if (brk_i || !enable_i) state_d = ST_EXIT_VID;
            end
            ST_EXIT_VID: begin
                if (vid_done_i) state_d = ST_EXIT_RATIO;
            end
            ST_EXIT_RATIO: begin
                if (ratio_done_i) state_d = ST_NOM;
            end
            default: state_d = ST_NOM;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/rvs_code_mux.sv
module rvs_code_mux
    import rvs_pkg::*;
#(
    parameter int RATIO_W = 5,
    parameter int VID_W   = 7
) (
    input  rvs_state_e         state_i,
    input  logic [RATIO_W-1:0] ratio_nom_i,
    input  logic [RATIO_W-1:0] ratio_low_i,
    input  logic [VID_W-1:0]   vid_nom_i,
    input  logic [VID_W-1:0]   vid_low_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [VID_W-1:0]   vid_o,
    output logic               ratio_req_o,
    output logic               vid_req_o,
    output logic               low_pwr_o
);
    rvs_ctl_t ctl;

    always_comb begin
        ctl = '0;
        unique case (state_i)
            ST_NOM:        ctl = '0;
            ST_ENT_RATIO:  begin ctl.ratio_low_sel = 1'b1; ctl.ratio_req = 1'b1; end
            ST_ENT_VID:    begin ctl.ratio_low_sel = 1'b1; ctl.vid_low_sel = 1'b1;
                                 ctl.vid_req = 1'b1; end
            ST_LOW:        begin ctl.ratio_low_sel = 1'b1; ctl.vid_low_sel = 1'b1;
                                 ctl.low_pwr = 1'b1; end
            ST_EXIT_VID:   begin ctl.ratio_low_sel = 1'b1; ctl.vid_req = 1'b1; end
            ST_EXIT_RATIO: ctl.ratio_req = 1'b1;
            default:       ctl = '0;
        endcase
    end

    assign ratio_o     = ctl.ratio_low_sel ? ratio_low_i : ratio_nom_i;
    assign vid_o       = ctl.vid_low_sel   ? vid_low_i   : vid_nom_i;
    assign ratio_req_o = ctl.ratio_req;
    assign vid_req_o   = ctl.vid_req;
    assign low_pwr_o   = ctl.low_pwr;
endmodule

// File: rtl/ratio_vid_sequencer.sv
module ratio_vid_sequencer
    import rvs_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int RATIO_W   = 5,
    parameter int VID_W     = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CORES-1:0] halted_i,
    input  logic                 enable_i,
    input  logic                 brk_i,
    input  logic [RATIO_W-1:0]   ratio_nom_i,
    input  logic [RATIO_W-1:0]   ratio_low_i,
    input  logic [VID_W-1:0]     vid_nom_i,
    input  logic [VID_W-1:0]     vid_low_i,
    input  logic                 ratio_done_i,
    input  logic                 vid_done_i,
    output logic [RATIO_W-1:0]   ratio_o,
    output logic [VID_W-1:0]     vid_o,
    output logic                 ratio_req_o,
    output logic                 vid_req_o,
    output logic                 low_pwr_o
);
    logic       enter_ok;
    rvs_state_e state_q;

    rvs_entry_qual #(.NUM_CORES(NUM_CORES)) u_qual (
        .halted_i   (halted_i),
        .enable_i   (enable_i),
        .enter_ok_o (enter_ok)
    );

    rvs_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enter_ok_i   (enter_ok),
        .enable_i     (enable_i),
        .brk_i        (brk_i),
        .ratio_done_i (ratio_done_i),
        .vid_done_i   (vid_done_i),
        .state_o      (state_q)
    );

    rvs_code_mux #(.RATIO_W(RATIO_W), .VID_W(VID_W)) u_mux (
        .state_i     (state_q),
        .ratio_nom_i (ratio_nom_i),
        .ratio_low_i (ratio_low_i),
        .vid_nom_i   (vid_nom_i),
        .vid_low_i   (vid_low_i),
        .ratio_o     (ratio_o),
        .vid_o       (vid_o),
        .ratio_req_o (ratio_req_o),
        .vid_req_o   (vid_req_o),
        .low_pwr_o   (low_pwr_o)
    );
endmodule

// File: rtl/rvs_checker.sv
module rvs_checker
    import rvs_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_CORES-1:0] halted_i,
    input logic                 enable_i,
    input logic                 brk_i,
    input logic                 ratio_done_i,
    input logic                 ratio_req_o,
    input logic                 vid_req_o,
    input logic                 low_pwr_o,
    input rvs_state_e           state_q
);
    logic all_halted;
    assign all_halted = &halted_i;

    AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENT_RATIO && $past(state_q) == ST_NOM)
            |-> $past(all_halted && enable_i && !brk_i)); // R2
    AST_ENTRY_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENT_VID)
            |-> ($past(state_q) == ST_ENT_RATIO || $past(state_q) == ST_ENT_VID)); // R3
    AST_EXIT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXIT_RATIO && $past(state_q) != ST_EXIT_RATIO)
            |-> ($past(state_q) == ST_EXIT_VID || $past(state_q) == ST_ENT_RATIO)); // R4
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ratio_req_o && !ratio_done_i) |=> ratio_req_o); // R5
    AST_LOW_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($past(low_pwr_o) && !low_pwr_o) |-> $past(brk_i || !enable_i)); // R7
    AST_DISABLED_STAYS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NOM && !enable_i) |=> (state_q == ST_NOM)); // R8
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ratio_req_o, vid_req_o})); // R9
endmodule

bind ratio_vid_sequencer rvs_checker #(.NUM_CORES(NUM_CORES)) u_rvs_chk (
    .clk          (clk),
    .rst          (rst),
    .halted_i     (halted_i),
    .enable_i     (enable_i),
    .brk_i        (brk_i),
    .ratio_done_i (ratio_done_i),
    .ratio_req_o  (ratio_req_o),
    .vid_req_o    (vid_req_o),
    .low_pwr_o    (low_pwr_o),
    .state_q      (state_q)
);

// File: tb/ratio_vid_sequencer_bench.sv
`timescale 1ns/1ps
module ratio_vid_sequencer_bench;
    localparam int NC = 3;
    localparam int RW = 5;
    localparam int VW = 6;
    localparam logic [RW-1:0] R_NOM = 5'd12;
    localparam logic [RW-1:0] R_LOW = 5'd6;
    localparam logic [VW-1:0] V_NOM = 6'd40;
    localparam logic [VW-1:0] V_LOW = 6'd20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NC-1:0] halted = '0;
    logic en = 1'b0, brk = 1'b0, d_r = 1'b0, d_v = 1'b0;
    logic [RW-1:0] ratio;
    logic [VW-1:0] vid;
    logic rreq, vreq, lowp;

    int total = 0, bad = 0, lat = 0, rcnt = 0, vcnt = 0;
    bit finished = 0;
    bit seen_low, seen_vlow, order_bad;

    // behavioural reference: commanded levels, pending requests, direction
    bit m_rl, m_vl, m_rr, m_vr, m_low, m_dn, m_pend;

    always #5 clk = ~clk;

    ratio_vid_sequencer #(.NUM_CORES(NC), .RATIO_W(RW), .VID_W(VW)) u_ratio_vid_sequencer (
        .clk(clk), .rst(rst), .halted_i(halted), .enable_i(en), .brk_i(brk),
        .ratio_nom_i(R_NOM), .ratio_low_i(R_LOW), .vid_nom_i(V_NOM), .vid_low_i(V_LOW),
        .ratio_done_i(d_r), .vid_done_i(d_v),
        .ratio_o(ratio), .vid_o(vid), .ratio_req_o(rreq), .vid_req_o(vreq), .low_pwr_o(lowp)
    );

    always @(posedge clk) begin
        if (rst) begin
            {m_rl, m_vl, m_rr, m_vr, m_low, m_dn, m_pend} = '0;
        end else begin
            bit was_entering, ab;
            was_entering = m_dn && (m_rr || m_vr);
            ab = m_pend || brk;
            if (m_rr) begin
                if (d_r) begin
                    m_rr = 0;
                    if (m_dn) begin
                        if (ab) begin m_dn = 0; m_rl = 0; m_rr = 1; end
                        else begin m_vl = 1; m_vr = 1; end
                    end
                end
            end else if (m_vr) begin
                if (d_v) begin
                    m_vr = 0;
                    if (m_dn) begin
                        if (ab) begin m_dn = 0; m_vl = 0; m_vr = 1; end
                        else m_low = 1;
                    end else begin
                        m_rl = 0; m_rr = 1;
                    end
                end
            end else if (m_low) begin
                if (brk || !en) begin m_low = 0; m_dn = 0; m_vl = 0; m_vr = 1; end
            end else if (en && (&halted) && !brk) begin
                m_dn = 1; m_rl = 1; m_rr = 1;
            end
            m_pend = was_entering ? ab : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check(ratio == (m_rl ? R_LOW : R_NOM), "R3 ratio_o vs model", ratio, m_rl ? R_LOW : R_NOM);
        check(vid == (m_vl ? V_LOW : V_NOM), "R4 vid_o vs model", vid, m_vl ? V_LOW : V_NOM);
        check({rreq, vreq} == {m_rr, m_vr}, "R5 request strobes vs model", {rreq, vreq}, {m_rr, m_vr});
        check(lowp == m_low, "R7 low_pwr_o vs model", lowp, m_low);
        check(!(rreq && vreq), "R9 both requests", {rreq, vreq}, 0);
        if (lowp) seen_low = 1;
        if (vid == V_LOW) seen_vlow = 1;
        if (vid == V_LOW && ratio != R_LOW) order_bad = 1;
        if (rreq) rcnt++; else rcnt = 0;
        if (vreq) vcnt++; else vcnt = 0;
        d_r = rreq && (rcnt > lat);
        d_v = vreq && (vcnt > lat);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_low(input string req);
        int k = 0;
        while (!lowp && k < 60) begin tick(); k++; end
        check(lowp == 1'b1, req, lowp, 1);
    endtask

    task automatic wait_nom(input string req);
        int k = 0;
        while ((rreq || vreq || lowp || ratio != R_NOM) && k < 60) begin tick(); k++; end
        check(ratio == R_NOM && vid == V_NOM && !rreq && !vreq, req, ratio, R_NOM);
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        tick();
        check(ratio == R_NOM && vid == V_NOM, "R1 reset codes", ratio, R_NOM);
        check(!rreq && !vreq && !lowp, "R1 reset strobes", {rreq, vreq, lowp}, 0);

        // R2: partial halt patterns keep nominal
        en = 1'b1;
        halted = 3'b011; run(6);
        halted = 3'b100; run(6);
        check(ratio == R_NOM && !rreq, "R2 partial halt stays nominal", ratio, R_NOM);

        // R8: enable clear, all halted
        en = 1'b0; halted = 3'b111; run(10);
        check(ratio == R_NOM && vid == V_NOM && !rreq, "R8 disabled stays nominal", vid, V_NOM);

        // R3: full entry, latency 2
        lat = 2; seen_vlow = 0; order_bad = 0;
        en = 1'b1;
        wait_low("R3 entry reaches low state");
        check(vid == V_LOW && ratio == R_LOW, "R3 low codes applied", vid, V_LOW);
        check(!order_bad, "R3 voltage lowered only after ratio", order_bad, 0);

        // R7: halted changes alone have no effect
        halted = 3'b001; run(8);
        check(lowp == 1'b1, "R7 halt change ignored in low state", lowp, 1);

        // R4: exit via break
        brk = 1'b1; tick(); brk = 1'b0; halted = '0;
        tick();
        check(vreq && vid == V_NOM && ratio == R_LOW, "R4 voltage restored first", ratio, R_LOW);
        wait_nom("R4 exit completes nominal");

        // R6: break during ratio step
        lat = 3; seen_low = 0; seen_vlow = 0;
        halted = 3'b111;
        begin int k = 0; while (!rreq && k < 20) begin tick(); k++; end end
        brk = 1'b1; tick(); brk = 1'b0; halted = '0;
        wait_nom("R6 abort in ratio step returns nominal");
        check(!seen_low && !seen_vlow, "R6 no voltage drop after ratio-step break", seen_vlow, 0);

        // R6: break during voltage step
        lat = 1; seen_low = 0;
        halted = 3'b111;
        begin int k = 0; while (!vreq && k < 20) begin tick(); k++; end end
        brk = 1'b1; tick(); brk = 1'b0; halted = '0;
        wait_nom("R6 abort in voltage step returns nominal");
        check(!seen_low, "R6 low flag never raised", seen_low, 0);

        // R7/R8: clearing enable leaves low state; latency 0
        lat = 0;
        halted = 3'b111;
        wait_low("R7 re-entry with zero latency");
        halted = '0; en = 1'b0;
        wait_nom("R7 enable clear exits low state");
        run(5);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule